// File: doc/BRIEF.md
# Filter Accelerator Debug and Status Unit

This block sits beside a multi-channel IIR filter engine. It gives a host bus a small register window onto two things. The first is debug access to the engine's two local memories: a delay-line store and a coefficient store, each holding 40-bit words. The second is the completion and arithmetic-exception events that the engine, its DMA and its MAC units raise. The filter datapath, the DMA engine and the MAC units live elsewhere. Here they appear only as event pulses and a single memory port.

For memory access, the host first sets the debug-enable and hold bits in the control register. It then writes a memory address, where the top address bit picks which store is used. One cycle later the block issues a memory read and captures the 40-bit word. The host collects that word from two read-only registers: the low one holds bits 31:0 and the high one holds bits 39:32. Two writable data registers, loaded low half first, carry a 40-bit word back into the selected store.

Completion events set a pair of DMA-done flags. Per-MAC exception events set sticky MAC flags. Both groups are cleared by reading them, and each group drives one interrupt line.

The host bus has no back-pressure: a request is accepted in every cycle that `bus_valid` is high. A read answers exactly one cycle later with `bus_rvalid`.

Top module: `iir_dbg_stat_unit`

## Requirements
- R1: After reset, all registers read as zero, and `irq_chan_done`, `irq_mac`, `mem_rd_en`, `mem_wr_en` and `bus_rvalid` are low.
- R2: The debug address register is at offset 1. Bit 11 of this register drives `mem_sel`, where 1 selects the coefficient store and 0 selects the delay-line store. Bits 10:0 drive `mem_addr`.
- R3: Access is enabled when control bit 0 (debug enable) and control bit 1 (hold) are both set. If access is enabled when the address register is written at clock edge k, then `mem_rd_en` is high for exactly the following cycle. At edge k+1 the word is captured into read-low (offset 2, bits 31:0) and read-high (offset 3, bits 7:0, with bits 31:8 reading zero).
- R4: If access is not enabled, an address write produces no `mem_rd_en` and no `mem_wr_en`, and both read data registers become zero.
- R5: Write-low (offset 4) and write-high (offset 5, bits 7:0) can be read back. If access is enabled, a write to offset 5 produces `mem_wr_en` for the next cycle with `mem_wdata = {high[7:0], low}`.
- R6: Control bit 2 selects the completion source. When it is 0, `evt_all_ch_done` counts as completion. When it is 1, `evt_slot_done` counts as completion. The source that is not selected has no effect.
- R7: A completion sets both DMA status bits together at offset 6: bit 0 is write-complete and bit 1 is all-channels. `irq_chan_done` is high while these bits are set.
- R8: Reading offset 6 returns the bits as they were before the read and clears both of them.
- R9: Offset 7 bits 3:0 hold one sticky flag per MAC unit, set by `mac_exc[i]`. `irq_mac` is the OR of these flags. Reading offset 7 returns the flags and clears them.
- R10: If an event arrives in the same cycle as a clearing read, the event wins. The read returns the old value and the bit ends up set.
- R11: `bus_rvalid` is high exactly one cycle after a read request, and `bus_rdata` is valid in that cycle. Writes to read-only offsets (2, 3, 6, 7) have no effect. The control register (bits 2:0) reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| evt_all_ch_done | input | 1 | All channels finished (pulse) |
| evt_slot_done | input | 1 | Time-slot pass finished (pulse) |
| mac_exc | input | 4 | Per-MAC arithmetic exception (pulse) |
| mem_rd_en | output | 1 | Debug memory read strobe |
| mem_wr_en | output | 1 | Debug memory write strobe |
| mem_sel | output | 1 | 1 = coefficient store, 0 = delay-line store |
| mem_addr | output | 11 | Word address |
| mem_wdata | output | 40 | Debug write word |
| mem_rdata | input | 40 | Word returned in the cycle of mem_rd_en |
| irq_chan_done | output | 1 | Channels-complete interrupt |
| irq_mac | output | 1 | MAC exception interrupt |

## Verification
The bench builds the block with its default parameters: an 11-bit word address, which places the store-select bit at position 11, four MAC units, and a 40-bit word split as 32 plus 8. With these values, words at both ends of the address range can be reached in both stores. The 8-bit high slice is exercised, and every MAC flag can be set individually or all at once. A table walk then covers each combination of completion-source setting and event pattern.

// File: rtl/iir_dbg_pkg.sv
package iir_dbg_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RG_CTRL  = 3'd0,
    RG_DADDR = 3'd1,
    RG_RDLO  = 3'd2,
    RG_RDHI  = 3'd3,
    RG_WRLO  = 3'd4,
    RG_WRHI  = 3'd5,
    RG_DMA   = 3'd6,
    RG_MAC   = 3'd7
  } reg_id_e;

  localparam int CTRL_W    = 3;
  localparam int CTRL_DBG  = 0;
  localparam int CTRL_HOLD = 1;
  localparam int CTRL_SLOT = 2;
  localparam int DMA_BITS  = 2;
endpackage

// File: rtl/iir_rc_flags.sv
module iir_rc_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         flags_o[i] <= 1'b0;
      else if (set_i[i])  flags_o[i] <= 1'b1;   // event beats clearing read
      else if (clr_i)     flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/iir_evt_status.sv
module iir_evt_status #(
  parameter int NMAC = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              slot_mode_i,
  input  logic                              evt_all_i,
  input  logic                              evt_slot_i,
  input  logic [NMAC-1:0]                   mac_exc_i,
  input  logic                              dma_rd_i,
  input  logic                              mac_rd_i,
  output logic [iir_dbg_pkg::DMA_BITS-1:0]  dma_flags_o,
  output logic [NMAC-1:0]                   mac_flags_o,
  output logic                              irq_cc_o,
  output logic                              irq_mac_o
);
  localparam int DB = iir_dbg_pkg::DMA_BITS;
  logic done;

  assign done = slot_mode_i ? evt_slot_i : evt_all_i;

  iir_rc_flags #(.N(DB)) i_dma_flags (
    .clk(clk), .rst_n(rst_n), .set_i({DB{done}}), .clr_i(dma_rd_i),
    .flags_o(dma_flags_o)
  );

  iir_rc_flags #(.N(NMAC)) i_mac_flags (
    .clk(clk), .rst_n(rst_n), .set_i(mac_exc_i), .clr_i(mac_rd_i),
    .flags_o(mac_flags_o)
  );

  assign irq_cc_o  = |dma_flags_o;
  assign irq_mac_o = |mac_flags_o;
endmodule

// File: rtl/iir_dbg_mem_access.sv
module iir_dbg_mem_access #(
  parameter int WORD_AW = 11,
  parameter int DW      = 40,
  parameter int BUS_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               access_on_i,
  input  logic               addr_we_i,
  input  logic               wrlo_we_i,
  input  logic               wrhi_we_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic [WORD_AW:0]   dbg_addr_o,
  output logic [DW-1:0]      rd_word_o,
  output logic [DW-1:0]      wr_word_o,
  output logic               mem_rd_en_o,
  output logic               mem_wr_en_o,
  output logic               mem_sel_o,
  output logic [WORD_AW-1:0] mem_addr_o
);
  localparam int HI_W = DW - BUS_W;

  logic              rd_pend, wr_pend;
  logic [BUS_W-1:0]  wr_lo;
  logic [HI_W-1:0]   wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_addr_o <= '0;
      rd_pend    <= 1'b0;
      wr_pend    <= 1'b0;
      wr_lo      <= '0;
      wr_hi      <= '0;
      rd_word_o  <= '0;
    end else begin
      rd_pend <= addr_we_i;
      wr_pend <= wrhi_we_i;
      if (addr_we_i) dbg_addr_o <= wdata_i[WORD_AW:0];
      if (wrlo_we_i) wr_lo      <= wdata_i;
      if (wrhi_we_i) wr_hi      <= wdata_i[HI_W-1:0];
      if (rd_pend)   rd_word_o  <= access_on_i ? mem_rdata_i : '0;
    end
  end

  assign wr_word_o   = {wr_hi, wr_lo};
  assign mem_rd_en_o = rd_pend & access_on_i;
  assign mem_wr_en_o = wr_pend & access_on_i;
  assign mem_sel_o   = dbg_addr_o[WORD_AW];
  assign mem_addr_o  = dbg_addr_o[WORD_AW-1:0];
endmodule

// File: rtl/iir_dbg_stat_unit.sv
module iir_dbg_stat_unit #(
  parameter int WORD_AW = 11,
  parameter int DW      = 40,
  parameter int BUS_W   = 32,
  parameter int NMAC    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [2:0]         bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_rvalid,
  input  logic               evt_all_ch_done,
  input  logic               evt_slot_done,
  input  logic [NMAC-1:0]    mac_exc,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic               mem_sel,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               irq_chan_done,
  output logic               irq_mac
);
  import iir_dbg_pkg::*;

  localparam int HI_W = DW - BUS_W;

  logic [CTRL_W-1:0]   ctrl;
  logic                access_on;
  logic                wr_hit, rd_hit;
  logic [WORD_AW:0]    dbg_addr;
  logic [DW-1:0]       rd_word, wr_word;
  logic [DMA_BITS-1:0] dma_flags;
  logic [NMAC-1:0]     mac_flags;
  logic [BUS_W-1:0]    rd_mux;

  assign wr_hit    = bus_valid &  bus_write;
  assign rd_hit    = bus_valid & ~bus_write;
  assign access_on = ctrl[CTRL_DBG] & ctrl[CTRL_HOLD];

  always_ff @(posedge clk) begin
    if (!rst_n)                                ctrl <= '0;
    else if (wr_hit && bus_addr == RG_CTRL)    ctrl <= bus_wdata[CTRL_W-1:0];
  end

  iir_dbg_mem_access #(.WORD_AW(WORD_AW), .DW(DW), .BUS_W(BUS_W)) i_mem (
    .clk(clk), .rst_n(rst_n), .access_on_i(access_on),
    .addr_we_i(wr_hit && bus_addr == RG_DADDR),
    .wrlo_we_i(wr_hit && bus_addr == RG_WRLO),
    .wrhi_we_i(wr_hit && bus_addr == RG_WRHI),
    .wdata_i(bus_wdata), .mem_rdata_i(mem_rdata),
    .dbg_addr_o(dbg_addr), .rd_word_o(rd_word), .wr_word_o(wr_word),
    .mem_rd_en_o(mem_rd_en), .mem_wr_en_o(mem_wr_en),
    .mem_sel_o(mem_sel), .mem_addr_o(mem_addr)
  );

  assign mem_wdata = wr_word;

  iir_evt_status #(.NMAC(NMAC)) i_evt (
    .clk(clk), .rst_n(rst_n), .slot_mode_i(ctrl[CTRL_SLOT]),
    .evt_all_i(evt_all_ch_done), .evt_slot_i(evt_slot_done), .mac_exc_i(mac_exc),
    .dma_rd_i(rd_hit && bus_addr == RG_DMA),
    .mac_rd_i(rd_hit && bus_addr == RG_MAC),
    .dma_flags_o(dma_flags), .mac_flags_o(mac_flags),
    .irq_cc_o(irq_chan_done), .irq_mac_o(irq_mac)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_id_e'(bus_addr))
      RG_CTRL:  rd_mux = BUS_W'(ctrl);
      RG_DADDR: rd_mux = BUS_W'(dbg_addr);
      RG_RDLO:  rd_mux = rd_word[BUS_W-1:0];
      RG_RDHI:  rd_mux = BUS_W'(rd_word[DW-1:BUS_W]);
      RG_WRLO:  rd_mux = wr_word[BUS_W-1:0];
      RG_WRHI:  rd_mux = BUS_W'(wr_word[BUS_W +: HI_W]);
      RG_DMA:   rd_mux = BUS_W'(dma_flags);
      RG_MAC:   rd_mux = BUS_W'(mac_flags);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_hit;
      if (rd_hit) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/iir_dbg_stat_checker.sv
module iir_dbg_stat_checker #(
  parameter int NMAC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [2:0]      bus_addr,
  input logic            bus_rvalid,
  input logic            evt_all_ch_done,
  input logic            evt_slot_done,
  input logic [NMAC-1:0] mac_exc,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic            irq_chan_done,
  input logic            irq_mac,
  input logic            access_on,
  input logic [2:0]      ctrl,
  input logic [1:0]      dma_flags
);
  import iir_dbg_pkg::*;

  assert_rd_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == RG_DADDR && access_on) |=> mem_rd_en);

  assert_rd_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> $past(bus_valid && bus_write && bus_addr == RG_DADDR));

  assert_no_touch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == RG_DADDR && !access_on) |=> !mem_rd_en);

  assert_wr_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(bus_valid && bus_write && bus_addr == RG_WRHI));

  assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_flags[0] == dma_flags[1]);

  assert_mac_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|mac_exc) |=> irq_mac);

  assert_evt_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTRL_SLOT] ? evt_slot_done : evt_all_ch_done) |=> irq_chan_done);

  assert_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_rsp_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write));
endmodule

bind iir_dbg_stat_unit iir_dbg_stat_checker #(.NMAC(NMAC)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid),
  .evt_all_ch_done(evt_all_ch_done), .evt_slot_done(evt_slot_done),
  .mac_exc(mac_exc), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .irq_chan_done(irq_chan_done), .irq_mac(irq_mac),
  .access_on(access_on), .ctrl(ctrl), .dma_flags(dma_flags)
);

// File: tb/test_iir_dbg_stat_unit.sv
module test_iir_dbg_stat_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic        evt_all_ch_done, evt_slot_done;
  logic [3:0]  mac_exc;
  logic        mem_rd_en, mem_wr_en, mem_sel;
  logic [10:0] mem_addr;
  logic [39:0] mem_wdata, mem_rdata;
  logic        irq_chan_done, irq_mac;

  int n_chk = 0, n_fail = 0, rd_touch = 0;
  logic done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iir_dbg_stat_unit i_iir_dbg_stat_unit (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_all_ch_done(evt_all_ch_done),
    .evt_slot_done(evt_slot_done), .mac_exc(mac_exc), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq_chan_done(irq_chan_done), .irq_mac(irq_mac)
  );

  function automatic logic [39:0] word_of(input logic sel, input logic [10:0] a);
    return {(sel ? 8'hC5 : 8'h5D) ^ a[7:0], (sel ? 16'hC0EF : 16'hD1A7), 5'b0, a};
  endfunction

  assign mem_rdata = word_of(mem_sel, mem_addr);

  always @(posedge clk) if (mem_rd_en) rd_touch <= rd_touch + 1;

  // {slot_mode, all_evt, slot_evt, mac[3:0], exp_dma[1:0], exp_mac[3:0]}
  localparam logic [12:0] TBL [8] = '{
    {1'b0, 1'b1, 1'b0, 4'b0000, 2'b11, 4'b0000},
    {1'b0, 1'b0, 1'b1, 4'b0000, 2'b00, 4'b0000},
    {1'b1, 1'b0, 1'b1, 4'b0000, 2'b11, 4'b0000},
    {1'b1, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000},
    {1'b0, 1'b0, 1'b0, 4'b0101, 2'b00, 4'b0101},
    {1'b1, 1'b1, 1'b1, 4'b1000, 2'b11, 4'b1000},
    {1'b0, 1'b1, 1'b1, 4'b1111, 2'b11, 4'b1111},
    {1'b0, 1'b0, 1'b0, 4'b0000, 2'b00, 4'b0000}
  };

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R11 rvalid", bus_rvalid, 1'b1);
    d = bus_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [39:0] w;
    int touch0;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_all_ch_done = 1'b0; evt_slot_done = 1'b0; mac_exc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_chan_done", irq_chan_done, 1'b0);
    chk("R1 irq_mac", irq_mac, 1'b0);
    chk("R1 mem_rd_en", mem_rd_en, 1'b0);
    chk("R1 mem_wr_en", mem_wr_en, 1'b0);
    chk("R1 rvalid", bus_rvalid, 1'b0);
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), d);
      chk("R1 register zero", d, 32'h0);
    end

    // Table walk over completion source and event patterns (R6 R7 R8 R9)
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, {29'b0, TBL[i][12], 2'b00});
      evt_all_ch_done = TBL[i][11]; evt_slot_done = TBL[i][10]; mac_exc = TBL[i][9:6];
      @(negedge clk);
      evt_all_ch_done = 1'b0; evt_slot_done = 1'b0; mac_exc = '0;
      chk("R7 irq_chan_done level", irq_chan_done, |TBL[i][5:4]);
      chk("R9 irq_mac is OR", irq_mac, |TBL[i][3:0]);
      rd(3'd6, d);
      chk("R6 R7 DMA status", d, {30'b0, TBL[i][5:4]});
      rd(3'd7, d);
      chk("R9 MAC status", d, {28'b0, TBL[i][3:0]});
      chk("R8 irq_chan_done cleared", irq_chan_done, 1'b0);
      chk("R9 irq_mac cleared", irq_mac, 1'b0);
      rd(3'd6, d);
      chk("R8 DMA status after clear", d, 32'h0);
    end

    // R11 control readback
    wr(3'd0, 32'hFFFF_FFFB);
    rd(3'd0, d);
    chk("R11 ctrl readback", d, 32'h3);

    // R2 address split, R3 debug read of coefficient store at top of range
    wr(3'd1, 32'h0000_0FFF);
    chk("R3 mem_rd_en next cycle", mem_rd_en, 1'b1);
    chk("R2 mem_sel coef", mem_sel, 1'b1);
    chk("R2 mem_addr", mem_addr, 11'h7FF);
    idle();
    chk("R3 mem_rd_en one cycle", mem_rd_en, 1'b0);
    w = word_of(1'b1, 11'h7FF);
    rd(3'd2, d);
    chk("R3 read low", d, w[31:0]);
    rd(3'd3, d);
    chk("R3 read high", d, {24'b0, w[39:32]});

    // R3 delay-line store, address 0x123
    wr(3'd1, 32'h0000_0123);
    chk("R2 mem_sel delay", mem_sel, 1'b0);
    idle();
    w = word_of(1'b0, 11'h123);
    rd(3'd2, d);
    chk("R3 delay read low", d, w[31:0]);
    rd(3'd3, d);
    chk("R3 delay read high", d, {24'b0, w[39:32]});

    // R11 writes to read-only registers ignored
    wr(3'd2, 32'hDEAD_BEEF);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd2, d);
    chk("R11 RO low unchanged", d, w[31:0]);
    rd(3'd3, d);
    chk("R11 RO high unchanged", d, {24'b0, w[39:32]});

    // R5 debug write with access enabled
    wr(3'd4, 32'h1234_5678);
    wr(3'd5, 32'hFFFF_FF9A);
    chk("R5 mem_wr_en", mem_wr_en, 1'b1);
    chk("R5 mem_wdata", mem_wdata, 40'h9A_1234_5678);
    idle();
    chk("R5 mem_wr_en one cycle", mem_wr_en, 1'b0);
    rd(3'd5, d);
    chk("R5 write-high readback", d, 32'h9A);
    rd(3'd4, d);
    chk("R5 write-low readback", d, 32'h1234_5678);

    // R4 hold cleared: no memory touch, data zero
    wr(3'd0, 32'h1);
    touch0 = rd_touch;
    wr(3'd1, 32'h0000_0800);
    chk("R4 no mem_rd_en", mem_rd_en, 1'b0);
    idle();
    rd(3'd2, d);
    chk("R4 low zero", d, 32'h0);
    rd(3'd3, d);
    chk("R4 high zero", d, 32'h0);
    wr(3'd5, 32'h11);
    chk("R4 R5 no mem_wr_en", mem_wr_en, 1'b0);
    wr(3'd0, 32'h2);
    wr(3'd1, 32'h0000_0001);
    chk("R4 debug bit off no read", mem_rd_en, 1'b0);
    idle();
    chk("R4 memory untouched", rd_touch - touch0, 0);

    // R10 event in the same cycle as clearing read
    wr(3'd0, 32'h0);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd6; evt_all_ch_done = 1'b1;
    mac_exc = 4'b0010;
    @(negedge clk);
    bus_valid = 1'b0; evt_all_ch_done = 1'b0; mac_exc = '0;
    chk("R10 read returns old DMA", bus_rdata, 32'h0);
    chk("R10 DMA event kept", irq_chan_done, 1'b1);
    bus_valid = 1'b1; bus_addr = 3'd7; mac_exc = 4'b0100;
    @(negedge clk);
    bus_valid = 1'b0; mac_exc = '0;
    chk("R10 read returns old MAC", bus_rdata, 32'h2);
    rd(3'd7, d);
    chk("R10 MAC event kept", d, 32'h4);
    rd(3'd6, d);
    chk("R10 DMA pair set", d, 32'h3);

    idle();
    finish_run();
  end
endmodule